// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Timer

This block produces the processor reset and a watchdog status flag for a chip that already has a digital supply-low indication and a slow timebase. The reset is held active while the supply-low flag is high. After the flag clears, the reset stays active for a fixed number of timebase ticks. Two lengths are available, and the `rstLenLong` input picks one. Software keeps the watchdog alive by toggling a strobe pin. Both rising and falling edges count. If the strobe stays still for a full watchdog period, the block issues a reset pulse of the same selected length and drives the timeout flag low.

Two watchdog periods are used. After every reset ends, whatever caused it, a long grace period applies. The grace period stays in force until the first strobe edge that arrives after the reset has been released. From then on the normal period applies. The normal period is short unless `periodLong` selects the long value. An enable input stands in for a strobe that is left floating. When the enable is low, the watchdog is off and the timeout flag stays high.

All counters advance only on cycles where `tickEn` is high. The strobe is brought into the clock domain through a two-flop synchronizer before its edges are detected.

Top module: `rst_wdog_timer`

## Requirements
- R1: The cycle after `supplyLow` is sampled high, `rstOutN` is 0. It stays 0 for as long as `supplyLow` remains high.
- R2: After `supplyLow` clears, `rstOutN` returns to 1 on exactly the 512th tick when `rstLenLong`=0, or the 2048th tick when `rstLenLong`=1.
- R3: `rstOut` is always the complement of `rstOutN`.
- R4: After a reset is released, the watchdog times out after 4096 ticks with no strobe edge. After the first strobe edge, with `periodLong`=0, it times out after 1024 ticks.
- R5: Rising and falling strobe edges both restart the watchdog period. Edges spaced at most 1023 ticks apart never cause a reset.
- R6: On a watchdog timeout, `rstOutN` and `wdTimeoutN` both go to 0 in the same cycle. The resulting reset pulse lasts the selected reset length.
- R7: With the strobe held constant, a reset pulse follows every 4096-tick grace period, repeatedly.
- R8: `wdTimeoutN` returns to 1 on the first strobe edge accepted after release. It is forced to 1 the cycle after `supplyLow` is sampled high.
- R9: While `wdEnable`=0, the watchdog never resets the block, and `wdTimeoutN` is 1 from the cycle after `wdEnable` is sampled low.
- R10: With `periodLong`=1, the normal period equals the 4096-tick grace period.
- R11: A strobe edge that takes effect while the reset is active is ignored. It neither restores `wdTimeoutN` nor ends the grace period. A strobe change that is set up before clock edge k is acted on at edge k+2.
- R12: The reset and watchdog counters advance only on cycles with `tickEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| tickEn | input | 1 | Timebase tick enable, one clock wide per tick |
| supplyLow | input | 1 | Supply below threshold, active high |
| strobe | input | 1 | Watchdog service strobe (asynchronous) |
| wdEnable | input | 1 | 1 enables the watchdog |
| periodLong | input | 1 | 1 selects the long normal watchdog period |
| rstLenLong | input | 1 | 1 selects the 2048-tick reset length, 0 selects 512 |
| rstOutN | output | 1 | Processor reset, active low |
| rstOut | output | 1 | Processor reset, active high |
| wdTimeoutN | output | 1 | Watchdog timeout flag, active low |

## Verification
The reset and the timeout flag are registered. They respond to `supplyLow`, `wdEnable` and the terminal tick one clock edge after the input is sampled. A strobe change takes effect on the third rising edge after it is driven, because of the two synchronizer flops plus the edge register. Inputs are driven and outputs sampled on the falling edge. Each strobe toggle is followed by three tick-free cycles before the bench counts any watchdog tick. Reset and timeout durations are measured by counting the ticks the bench itself drove, up to the first falling edge where the output has changed. Those counts are compared with the tick counts that the requirements call for.

// File: rtl/rst_wdog_pkg.sv
package rst_wdog_pkg;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic rstClr;   // clear the reset-length counter (priority over inc)
    logic rstInc;   // advance the reset-length counter
    logic wdClr;    // clear the watchdog counter (priority over inc)
    logic wdInc;    // advance the watchdog counter
    logic wdLong;   // compare the watchdog counter against the long limit
  } cntCtrl_t;

endpackage

// File: rtl/rst_wdog_counters.sv
module rst_wdog_counters
  import rst_wdog_pkg::*;
#(
  parameter int RST_SHORT_TICKS = 512,
  parameter int RST_LONG_TICKS  = 2048,
  parameter int WD_NORMAL_TICKS = 1024,
  parameter int WD_GRACE_TICKS  = 4096
) (
  input  logic     clk,
  input  logic     rstN,
  input  cntCtrl_t ctl,
  input  logic     rstLenLong,
  output logic     rstDone,
  output logic     wdDone
);

  localparam int RST_MAX = (RST_LONG_TICKS > RST_SHORT_TICKS) ? RST_LONG_TICKS : RST_SHORT_TICKS;
  localparam int WD_MAX  = (WD_GRACE_TICKS > WD_NORMAL_TICKS) ? WD_GRACE_TICKS : WD_NORMAL_TICKS;
  localparam int RCW     = $clog2(RST_MAX + 1);
  localparam int WCW     = $clog2(WD_MAX + 1);

  localparam logic [RCW-1:0] RST_SHORT_END = RCW'(RST_SHORT_TICKS - 1);
  localparam logic [RCW-1:0] RST_LONG_END  = RCW'(RST_LONG_TICKS - 1);
  localparam logic [RCW-1:0] RST_MAX_END   = RCW'(RST_MAX - 1);
  localparam logic [WCW-1:0] WD_NORMAL_END = WCW'(WD_NORMAL_TICKS - 1);
  localparam logic [WCW-1:0] WD_GRACE_END  = WCW'(WD_GRACE_TICKS - 1);
  localparam logic [WCW-1:0] WD_MAX_END    = WCW'(WD_MAX - 1);

  logic [RCW-1:0] rstCnt;
  logic [WCW-1:0] wdCnt;
  logic [RCW-1:0] rstEnd;
  logic [WCW-1:0] wdEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rstCnt <= '0;
    else if (ctl.rstClr) rstCnt <= '0;
    else if (ctl.rstInc) rstCnt <= rstCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wdCnt <= '0;
    else if (ctl.wdClr) wdCnt <= '0;
    else if (ctl.wdInc) wdCnt <= wdCnt + 1'b1;
  end

  always_comb begin
    rstEnd  = rstLenLong ? RST_LONG_END : RST_SHORT_END;
    wdEnd   = ctl.wdLong ? WD_GRACE_END : WD_NORMAL_END;
    // >= so that a select change mid-count can never let a counter run past its end
    rstDone = (rstCnt >= rstEnd);
    wdDone  = (wdCnt >= wdEnd);
  end

  // R2: reset-length counter never exceeds the longest reset length
  p_rst_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= RST_MAX_END);

  // R4: watchdog counter never exceeds the longest watchdog period
  p_wd_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WD_MAX_END);

endmodule

// File: rtl/rst_wdog_ctrl.sv
module rst_wdog_ctrl
  import rst_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     supplyLow,
  input  logic     strobe,
  input  logic     wdEnable,
  input  logic     periodLong,
  input  logic     rstDone,
  input  logic     wdDone,
  output cntCtrl_t ctl,
  output logic     rstActive,
  output logic     wdTimeoutN
);

  // syncChain[0..SYNC_STAGES-1] synchronize, syncChain[SYNC_STAGES] holds the previous value
  logic [SYNC_STAGES:0] syncChain;
  logic strobeEdge;
  logic wdRun;
  logic timeoutHit;
  logic releaseHit;
  logic graceOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= strobe;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[i] <= 1'b0;
      else       syncChain[i] <= syncChain[i-1];
    end
  end

  always_comb begin
    strobeEdge = syncChain[SYNC_STAGES-1] ^ syncChain[SYNC_STAGES];
    wdRun      = !rstActive && wdEnable;
    timeoutHit = wdRun && tickEn && !strobeEdge && wdDone;
    releaseHit = rstActive && !supplyLow && tickEn && rstDone;

    ctl.rstClr = supplyLow || !rstActive || releaseHit;
    ctl.rstInc = tickEn;
    ctl.wdClr  = !wdRun || strobeEdge || timeoutHit;
    ctl.wdInc  = tickEn;
    ctl.wdLong = graceOn || periodLong;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstActive  <= 1'b1;
      graceOn    <= 1'b1;
      wdTimeoutN <= 1'b1;
    end else begin
      if (supplyLow)       rstActive <= 1'b1;
      else if (releaseHit) rstActive <= 1'b0;
      else if (timeoutHit) rstActive <= 1'b1;

      if (rstActive)                  graceOn <= 1'b1;
      else if (wdRun && strobeEdge)   graceOn <= 1'b0;

      if (supplyLow || !wdEnable)     wdTimeoutN <= 1'b1;
      else if (wdRun && strobeEdge)   wdTimeoutN <= 1'b1;
      else if (timeoutHit)            wdTimeoutN <= 1'b0;
    end
  end

  // R1: a low supply holds the reset active
  p_supply_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> rstActive);

  // R2: reset is released only on a tick with the supply good
  p_release_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> ($past(tickEn) && !$past(supplyLow)));

  // R6: a timeout flag drop coincides with a fresh reset pulse
  p_timeout_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdTimeoutN) |-> (rstActive && !$past(rstActive)));

  // R8: low supply forces the timeout flag high
  p_wdo_supply_r8: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> wdTimeoutN);

  // R9: a disabled watchdog keeps its flag high
  p_wdo_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> wdTimeoutN);

  // R12: without a tick and with the supply good, the reset state cannot move
  p_tick_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !supplyLow) |=> $stable(rstActive));

endmodule

// File: rtl/rst_wdog_timer.sv
module rst_wdog_timer
  import rst_wdog_pkg::*;
#(
  parameter int RST_SHORT_TICKS = 512,
  parameter int RST_LONG_TICKS  = 2048,
  parameter int WD_NORMAL_TICKS = 1024,
  parameter int WD_GRACE_TICKS  = 4096,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic supplyLow,
  input  logic strobe,
  input  logic wdEnable,
  input  logic periodLong,
  input  logic rstLenLong,
  output logic rstOutN,
  output logic rstOut,
  output logic wdTimeoutN
);

  cntCtrl_t ctl;
  logic     rstDone;
  logic     wdDone;
  logic     rstActive;

  rst_wdog_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .supplyLow  (supplyLow),
    .strobe     (strobe),
    .wdEnable   (wdEnable),
    .periodLong (periodLong),
    .rstDone    (rstDone),
    .wdDone     (wdDone),
    .ctl        (ctl),
    .rstActive  (rstActive),
    .wdTimeoutN (wdTimeoutN)
  );

  rst_wdog_counters #(
    .RST_SHORT_TICKS (RST_SHORT_TICKS),
    .RST_LONG_TICKS  (RST_LONG_TICKS),
    .WD_NORMAL_TICKS (WD_NORMAL_TICKS),
    .WD_GRACE_TICKS  (WD_GRACE_TICKS)
  ) u_cnt (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rstLenLong (rstLenLong),
    .rstDone    (rstDone),
    .wdDone     (wdDone)
  );

  assign rstOutN = !rstActive;
  assign rstOut  = rstActive;

endmodule

// File: tb/sim_rst_wdog_timer.sv
`timescale 1ns/1ps
module sim_rst_wdog_timer;

  logic clk = 1'b0;
  logic rstN, tickEn, supplyLow, strobe, wdEnable, periodLong, rstLenLong;
  logic rstOutN, rstOut, wdTimeoutN;

  int nChecks = 0;
  int nFail   = 0;
  int compErr = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  rst_wdog_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .supplyLow(supplyLow),
    .strobe(strobe), .wdEnable(wdEnable), .periodLong(periodLong),
    .rstLenLong(rstLenLong), .rstOutN(rstOutN), .rstOut(rstOut),
    .wdTimeoutN(wdTimeoutN)
  );

  function automatic int expRstLen(input bit longSel);
    return longSel ? 2048 : 512;
  endfunction

  function automatic int expWdLimit(input bit grace, input bit longSel);
    return (grace || longSel) ? 4096 : 1024;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic t);
    tickEn = t;
    @(negedge clk);
    if (rstOut !== ~rstOutN) compErr++;
  endtask

  task automatic waitRelease(input int dens, output int ticks);
    ticks = 0;
    while (rstOutN == 1'b0 && ticks < 10000) begin
      logic t;
      t = ($urandom_range(99) < dens);
      ticks += int'(t);
      cyc(t);
    end
    tickEn = 1'b0;
  endtask

  task automatic measureTimeout(input int dens, output int ticks);
    ticks = 0;
    while (rstOutN == 1'b1 && ticks < 10000) begin
      logic t;
      t = ($urandom_range(99) < dens);
      ticks += int'(t);
      cyc(t);
    end
    tickEn = 1'b0;
  endtask

  task automatic driveTicks(input int n, input int dens, inout bit saw);
    int k = 0;
    while (k < n) begin
      logic t;
      t = ($urandom_range(99) < dens);
      k += int'(t);
      cyc(t);
      if (rstOutN == 1'b0) saw = 1'b1;
    end
    tickEn = 1'b0;
  endtask

  // toggle, then three tick-free cycles until the edge has been consumed
  task automatic toggleStrobe();
    strobe = ~strobe;
    cyc(1'b0); cyc(1'b0); cyc(1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    bit saw;
    void'($urandom(32'd4242));
    rstN = 1'b0; tickEn = 1'b0; supplyLow = 1'b1; strobe = 1'b0;
    wdEnable = 1'b1; periodLong = 1'b0; rstLenLong = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset state rstOutN", rstOutN, 0);
    chk("R3 reset state rstOut", rstOut, 1);
    chk("R8 reset state wdTimeoutN", wdTimeoutN, 1);
    rstN = 1'b1;

    // R1: held while supply low, even with ticks
    saw = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1);
      if (rstOutN) saw = 1;
    end
    chk("R1 held during supplyLow", saw, 0);

    // R2: short reset length
    supplyLow = 1'b0;
    waitRelease(100, n);
    chk("R2 short reset length", n, expRstLen(0));

    // R4 grace period, R6 flag and pulse
    measureTimeout(100, n);
    chk("R4 grace period", n, expWdLimit(1, 0));
    chk("R6 flag low at timeout", wdTimeoutN, 0);
    waitRelease(100, n);
    chk("R6 pulse length", n, expRstLen(0));
    chk("R8 flag stays low after release", wdTimeoutN, 0);

    // R7: repeats with constant strobe
    measureTimeout(100, n);
    chk("R7 repeated grace timeout", n, expWdLimit(1, 0));
    waitRelease(100, n);
    chk("R7 repeated pulse length", n, expRstLen(0));

    // R8 flag restored by edge; R4 normal period afterwards
    toggleStrobe();
    chk("R8 flag high after edge", wdTimeoutN, 1);
    measureTimeout(100, n);
    chk("R4 normal period", n, expWdLimit(0, 0));
    chk("R6 flag low at normal timeout", wdTimeoutN, 0);
    waitRelease(100, n);
    chk("R6 pulse length after normal timeout", n, expRstLen(0));
    toggleStrobe();

    // R5: random servicing with both edge polarities, plus 1023-tick boundary
    saw = 0;
    for (int i = 0; i < 16; i++) begin
      driveTicks(int'($urandom_range(1020, 1)), int'($urandom_range(100, 30)), saw);
      toggleStrobe();
    end
    driveTicks(1023, 100, saw); toggleStrobe();
    driveTicks(1023, 100, saw); toggleStrobe();
    chk("R5 serviced watchdog never resets", saw, 0);
    chk("R5 flag high while serviced", wdTimeoutN, 1);

    // R8 forced high by supply low; R1 mid-run; R2/R12 long length with sparse ticks
    measureTimeout(100, n);
    chk("R4 normal period again", n, expWdLimit(0, 0));
    supplyLow = 1'b1;
    cyc(1'b1);
    chk("R8 flag forced high by supplyLow", wdTimeoutN, 1);
    saw = 0;
    for (int i = 0; i < 50; i++) begin
      cyc(1'b1);
      if (rstOutN) saw = 1;
    end
    chk("R1 reset held while supply low", saw, 0);
    rstLenLong = 1'b1;
    supplyLow = 1'b0;
    waitRelease(40, n);
    chk("R2 R12 long reset length in ticks", n, expRstLen(1));

    // R10: long normal period
    periodLong = 1'b1;
    toggleStrobe();
    measureTimeout(100, n);
    chk("R10 long normal period", n, expWdLimit(0, 1));

    // R11: edge during reset ignored
    toggleStrobe();
    chk("R11 flag unchanged by edge in reset", wdTimeoutN, 0);
    periodLong = 1'b0;
    waitRelease(100, n);
    chk("R11 pulse length", n, expRstLen(1));
    chk("R11 flag still low after release", wdTimeoutN, 0);
    measureTimeout(100, n);
    chk("R11 grace kept after ignored edge", n, expWdLimit(1, 0));

    // R9: disabled watchdog
    wdEnable = 1'b0;
    cyc(1'b0);
    chk("R9 flag high when disabled", wdTimeoutN, 1);
    rstLenLong = 1'b0;
    waitRelease(100, n);
    chk("R9 pulse length", n, expRstLen(0));
    saw = 0;
    driveTicks(6000, 100, saw);
    chk("R9 no watchdog reset when disabled", saw, 0);
    chk("R9 flag stays high", wdTimeoutN, 1);

    // re-enable: grace still in force
    wdEnable = 1'b1;
    measureTimeout(100, n);
    chk("R4 grace after re-enable", n, expWdLimit(1, 0));

    chk("R3 complement mismatches", compErr, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule